// File: doc/BRIEF.md
# Priority Threshold Interrupt Selector

This block is the per-target decision stage of a platform interrupt controller. It receives the pending vector produced by the source gateways, one priority value per source, the enable mask of its target and that target's threshold. From these it finds the best enabled pending source and registers two results. The first is the identifier of that source, which is also the value returned when the target claims. The second is a request line to the target.

Identifiers are one-based: source bit `k` is reported as `k+1`, and 0 means that no source is available. The claim value ignores the threshold. The request line asserts only when the chosen source's priority is strictly above the threshold. A one-cycle claim strobe is decoded into a one-hot clear vector that goes back to the gateways, so that the claimed source's pending bit can be dropped.

Top module: `irq_target_select`

## Requirements
- R1: Source bit k of `pending_i` is reported on `irq_id_o` as identifier k+1. Identifier 0 means that no source is selected.
- R2: Among sources that are both pending and enabled, `irq_id_o` names the one with the largest effective priority. Source k's priority is field `prio_i[k*PRIO_W +: PRIO_W]`.
- R3: When the largest effective priority is shared by several candidates, the lowest identifier is reported.
- R4: `irq_o` is 1 only when a source is selected and its effective priority is strictly greater than `threshold_i`.
- R5: A selected source with priority 0 never raises `irq_o`. A threshold equal to MAX_PRIO keeps `irq_o` at 0 whatever the priorities are.
- R6: `irq_id_o` does not depend on `threshold_i`. A pending, enabled source at or below the threshold is still reported.
- R7: When no source is both pending and enabled, `irq_id_o` is 0 and `irq_o` is 0.
- R8: A pending source whose `enable_i` bit is 0 is never selected. A lower-priority enabled source is reported in its place. There is no global disable.
- R9: `irq_id_o` and `irq_o` are registered. They reflect the inputs sampled at the previous rising clock edge.
- R10: While `claim_i` is 1 and `irq_id_o` is nonzero, `claim_clr_o` has exactly bit `irq_id_o-1` set, in that same cycle. Otherwise `claim_clr_o` is all zero.
- R11: While `rst_ni` is low, `irq_o` and `irq_id_o` are 0.
- R12: A priority field above MAX_PRIO is treated as MAX_PRIO, both for ordering and for the threshold comparison.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| pending_i | input | N_SRC | Pending bits from the gateways |
| enable_i | input | N_SRC | Per-source enable mask for this target |
| prio_i | input | N_SRC*PRIO_W | Packed per-source priorities, source k at bits k*PRIO_W |
| threshold_i | input | PRIO_W | Target threshold |
| claim_i | input | 1 | One-cycle claim strobe |
| irq_o | output | 1 | Request line to the target |
| irq_id_o | output | ID_W | Selected identifier and claim read value |
| claim_clr_o | output | N_SRC | One-hot pending-clear vector to the gateways |

## Verification
A claim strobe and a change of selection can fall in the same cycle. In that cycle the strobe must clear the source that is currently being reported, not the one that has just become best. The bench raises a higher-priority pending bit in the same cycle that it asserts `claim_i`. Within that cycle it checks that `claim_clr_o` still points at the old identifier. After the next edge it checks that `irq_id_o` has moved to the newcomer.

// File: rtl/irq_sel_pkg.sv
package irq_sel_pkg;
  typedef enum logic [0:0] {PICK_LEFT = 1'b0, PICK_RIGHT = 1'b1} pick_e;
endpackage

// File: rtl/irq_sel_node.sv
module irq_sel_node
  import irq_sel_pkg::*;
#(
  parameter int PRIO_W = 3,
  parameter int ID_W   = 4
) (
  input  logic              a_vld_i,
  input  logic [PRIO_W-1:0] a_prio_i,
  input  logic [ID_W-1:0]   a_id_i,
  input  logic              b_vld_i,
  input  logic [PRIO_W-1:0] b_prio_i,
  input  logic [ID_W-1:0]   b_id_i,
  output logic              y_vld_o,
  output logic [PRIO_W-1:0] y_prio_o,
  output logic [ID_W-1:0]   y_id_o
);
  pick_e pick;

  // left side always holds lower ids: ties stay left
  always_comb begin
    pick = (a_vld_i && (!b_vld_i || a_prio_i >= b_prio_i)) ? PICK_LEFT : PICK_RIGHT;
    if (pick == PICK_LEFT) begin
      y_vld_o  = a_vld_i;
      y_prio_o = a_prio_i;
      y_id_o   = a_id_i;
    end else begin
      y_vld_o  = b_vld_i;
      y_prio_o = b_prio_i;
      y_id_o   = b_id_i;
    end
  end
endmodule

// File: rtl/irq_sel_tree.sv
module irq_sel_tree #(
  parameter int N_SRC    = 8,
  parameter int MAX_PRIO = 6,
  parameter int PRIO_W   = $clog2(MAX_PRIO + 1),
  parameter int ID_W     = $clog2(N_SRC + 1)
) (
  input  logic [N_SRC-1:0]        req_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  output logic                    vld_o,
  output logic [PRIO_W-1:0]       prio_o,
  output logic [ID_W-1:0]         id_o
);
  localparam int LEAVES = 2 ** $clog2(N_SRC);
  localparam int NODES  = 2 * LEAVES - 1;
  localparam logic [PRIO_W-1:0] PMAX = PRIO_W'(MAX_PRIO);

  logic              nv  [NODES];
  logic [PRIO_W-1:0] np  [NODES];
  logic [ID_W-1:0]   nid [NODES];

  for (genvar j = 0; j < LEAVES; j++) begin : g_leaf
    if (j < N_SRC) begin : g_src
      logic [PRIO_W-1:0] raw;
      assign raw                = prio_i[j*PRIO_W +: PRIO_W];
      assign nv[LEAVES-1+j]     = req_i[j];
      assign np[LEAVES-1+j]     = (raw > PMAX) ? PMAX : raw;
      assign nid[LEAVES-1+j]    = ID_W'(j + 1);
    end else begin : g_pad
      assign nv[LEAVES-1+j]     = 1'b0;
      assign np[LEAVES-1+j]     = '0;
      assign nid[LEAVES-1+j]    = '0;
    end
  end

  for (genvar i = 0; i < LEAVES - 1; i++) begin : g_node
    irq_sel_node #(.PRIO_W(PRIO_W), .ID_W(ID_W)) u_node (
      .a_vld_i (nv[2*i+1]),
      .a_prio_i(np[2*i+1]),
      .a_id_i  (nid[2*i+1]),
      .b_vld_i (nv[2*i+2]),
      .b_prio_i(np[2*i+2]),
      .b_id_i  (nid[2*i+2]),
      .y_vld_o (nv[i]),
      .y_prio_o(np[i]),
      .y_id_o  (nid[i])
    );
  end

  assign vld_o  = nv[0];
  assign prio_o = np[0];
  assign id_o   = nv[0] ? nid[0] : '0;
endmodule

// File: rtl/irq_target_select.sv
module irq_target_select #(
  parameter int N_SRC    = 8,
  parameter int MAX_PRIO = 6,
  parameter int PRIO_W   = $clog2(MAX_PRIO + 1),
  parameter int ID_W     = $clog2(N_SRC + 1)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [N_SRC-1:0]        pending_i,
  input  logic [N_SRC-1:0]        enable_i,
  input  logic [N_SRC*PRIO_W-1:0] prio_i,
  input  logic [PRIO_W-1:0]       threshold_i,
  input  logic                    claim_i,
  output logic                    irq_o,
  output logic [ID_W-1:0]         irq_id_o,
  output logic [N_SRC-1:0]        claim_clr_o
);
  logic [N_SRC-1:0]  req;
  logic              best_vld;
  logic [PRIO_W-1:0] best_prio;
  logic [ID_W-1:0]   best_id;
  logic              irq_q;
  logic [ID_W-1:0]   id_q;

  assign req = pending_i & enable_i;

  irq_sel_tree #(
    .N_SRC(N_SRC), .MAX_PRIO(MAX_PRIO), .PRIO_W(PRIO_W), .ID_W(ID_W)
  ) u_tree (
    .req_i (req),
    .prio_i(prio_i),
    .vld_o (best_vld),
    .prio_o(best_prio),
    .id_o  (best_id)
  );

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      irq_q <= 1'b0;
      id_q  <= '0;
    end else begin
      irq_q <= best_vld && (best_prio > threshold_i);
      id_q  <= best_id;
    end
  end

  // claim clears whatever id is being reported this cycle
  for (genvar k = 0; k < N_SRC; k++) begin : g_clr
    assign claim_clr_o[k] = claim_i && (id_q == ID_W'(k + 1));
  end

  assign irq_o    = irq_q;
  assign irq_id_o = id_q;
endmodule

// File: rtl/irq_target_select_chk.sv
module irq_target_select_chk #(
  parameter int N_SRC    = 8,
  parameter int MAX_PRIO = 6,
  parameter int PRIO_W   = $clog2(MAX_PRIO + 1),
  parameter int ID_W     = $clog2(N_SRC + 1)
) (
  input logic                    clk_i,
  input logic                    rst_ni,
  input logic [N_SRC-1:0]        pending_i,
  input logic [N_SRC-1:0]        enable_i,
  input logic [N_SRC*PRIO_W-1:0] prio_i,
  input logic [PRIO_W-1:0]       threshold_i,
  input logic                    claim_i,
  input logic                    irq_o,
  input logic [ID_W-1:0]         irq_id_o,
  input logic [N_SRC-1:0]        claim_clr_o
);
  a_r1_id_range: assert property (@(posedge clk_i) disable iff (!rst_ni)
    int'(irq_id_o) <= N_SRC);

  a_r4_irq_needs_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    irq_o |-> irq_id_o != '0);

  a_r5_max_thr_quiet: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (threshold_i == PRIO_W'(MAX_PRIO)) |=> !irq_o);

  a_r7_none_no_id: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((pending_i & enable_i) == '0) |=> (irq_id_o == '0 && !irq_o));

  a_r10_clr_onehot: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(claim_clr_o));

  a_r10_clr_needs_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !claim_i |-> claim_clr_o == '0);

  a_r10_clr_on_claim: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (claim_i && irq_id_o != '0) |-> $countones(claim_clr_o) == 1);
endmodule

bind irq_target_select irq_target_select_chk #(
  .N_SRC(N_SRC), .MAX_PRIO(MAX_PRIO), .PRIO_W(PRIO_W), .ID_W(ID_W)
) u_chk (.*);

// File: tb/irq_target_select_bench.sv
`timescale 1ns/1ps
module irq_target_select_bench;
  localparam int N_SRC    = 8;
  localparam int MAX_PRIO = 6;
  localparam int PRIO_W   = 3;
  localparam int ID_W     = 4;

  logic                    clk_i = 1'b0;
  logic                    rst_ni = 1'b0;
  logic [N_SRC-1:0]        pending_i = '0;
  logic [N_SRC-1:0]        enable_i = '0;
  logic [N_SRC*PRIO_W-1:0] prio_i = '0;
  logic [PRIO_W-1:0]       threshold_i = '0;
  logic                    claim_i = 1'b0;
  logic                    irq_o;
  logic [ID_W-1:0]         irq_id_o;
  logic [N_SRC-1:0]        claim_clr_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  irq_target_select #(.N_SRC(N_SRC), .MAX_PRIO(MAX_PRIO)) u_irq_target_select (.*);

  task automatic check(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic set_prio(input int src, input int val);
    prio_i[src*PRIO_W +: PRIO_W] = PRIO_W'(val);
  endtask

  // drive at negedge, sample after the next rising edge
  task automatic settle();
    @(posedge clk_i);
    #1;
  endtask

  task automatic clear_all();
    @(negedge clk_i);
    pending_i = '0; enable_i = '0; prio_i = '0; threshold_i = '0; claim_i = 1'b0;
    settle();
  endtask

  task automatic t_reset();
    #1;
    check("R11 irq in reset", irq_o, 0);
    check("R11 id in reset", irq_id_o, 0);
    @(negedge clk_i);
    pending_i = 8'hff; enable_i = 8'hff; set_prio(0, 5);
    #1;
    check("R11 id held in reset", irq_id_o, 0);
    @(negedge clk_i);
    rst_ni = 1'b1;
    clear_all();
  endtask

  task automatic t_id();
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'h01; set_prio(0, 3);
    settle();
    check("R1 bit0 id", irq_id_o, 1);
    check("R4 irq above thr", irq_o, 1);
    @(negedge clk_i);
    pending_i = 8'h80; set_prio(7, 2);
    settle();
    check("R1 bit7 id", irq_id_o, 8);
    clear_all();
  endtask

  task automatic t_prio_tie();
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'b0010_0001; set_prio(0, 2); set_prio(5, 5);
    settle();
    check("R2 higher prio wins", irq_id_o, 6);
    @(negedge clk_i);
    pending_i = 8'b0001_0100; set_prio(2, 4); set_prio(4, 4);
    settle();
    check("R3 tie lowest id", irq_id_o, 3);
    clear_all();
  endtask

  task automatic t_threshold();
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'h08; set_prio(3, 3); threshold_i = 3'd3;
    settle();
    check("R4 equal thr no irq", irq_o, 0);
    check("R6 id ignores thr", irq_id_o, 4);
    @(negedge clk_i);
    threshold_i = 3'd2;
    settle();
    check("R4 above thr irq", irq_o, 1);
    @(negedge clk_i);
    threshold_i = 3'd5;
    settle();
    check("R6 below thr still reported", irq_id_o, 4);
    clear_all();
  endtask

  task automatic t_zero_max();
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'h01; set_prio(0, 0);
    settle();
    check("R5 prio0 no irq", irq_o, 0);
    check("R5 prio0 id", irq_id_o, 1);
    @(negedge clk_i);
    set_prio(0, 6); threshold_i = 3'd6;
    settle();
    check("R5 max thr no irq", irq_o, 0);
    clear_all();
  endtask

  task automatic t_mask();
    @(negedge clk_i);
    pending_i = 8'h03; set_prio(0, 1); set_prio(1, 5); enable_i = 8'h01;
    settle();
    check("R8 disabled src skipped", irq_id_o, 1);
    @(negedge clk_i);
    enable_i = 8'h00;
    settle();
    check("R7 none enabled id", irq_id_o, 0);
    check("R7 none enabled irq", irq_o, 0);
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'h00;
    settle();
    check("R7 none pending id", irq_id_o, 0);
    clear_all();
  endtask

  task automatic t_latency();
    @(negedge clk_i);
    enable_i = 8'hff; set_prio(2, 4); pending_i = 8'h04;
    #1;
    check("R9 before edge old id", irq_id_o, 0);
    check("R9 before edge old irq", irq_o, 0);
    settle();
    check("R9 after edge id", irq_id_o, 3);
    check("R9 after edge irq", irq_o, 1);
    clear_all();
  endtask

  task automatic t_claim();
    @(negedge clk_i);
    enable_i = 8'hff; set_prio(1, 2); pending_i = 8'h02;
    settle();
    @(negedge clk_i);
    claim_i = 1'b1; set_prio(6, 5); pending_i = 8'h42; // collision with new best
    #1;
    check("R10 clr old id in claim cycle", claim_clr_o, 8'h02);
    settle();
    check("R10 id moves to newcomer", irq_id_o, 7);
    check("R10 clr follows new id", claim_clr_o, 8'h40);
    @(negedge clk_i);
    claim_i = 1'b0;
    #1;
    check("R10 no clr without claim", claim_clr_o, 0);
    @(negedge clk_i);
    pending_i = 8'h00;
    settle();
    @(negedge clk_i);
    claim_i = 1'b1;
    #1;
    check("R10 claim with id0 clears none", claim_clr_o, 0);
    @(negedge clk_i);
    claim_i = 1'b0;
    clear_all();
  endtask

  task automatic t_saturate();
    @(negedge clk_i);
    enable_i = 8'hff; pending_i = 8'h0a; set_prio(1, 6); set_prio(3, 7); threshold_i = 3'd5;
    settle();
    check("R12 saturated tie lowest id", irq_id_o, 2);
    check("R12 irq above thr", irq_o, 1);
    @(negedge clk_i);
    pending_i = 8'h08; threshold_i = 3'd6;
    settle();
    check("R12 prio7 held at max thr", irq_o, 0);
    clear_all();
  endtask

  initial begin
    #200000;
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog expired");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    t_reset();
    t_id();
    t_prio_tie();
    t_threshold();
    t_zero_max();
    t_mask();
    t_latency();
    t_claim();
    t_saturate();
    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule